// File: doc/BRIEF.md
# Configurable macro-gate logic element

This block is one basic logic element of a heterogeneous programmable fabric. It holds two independent logic resources side by side. One is a 6-input lookup table whose 64-entry truth table comes from configuration storage. The other is a hardwired macro-gate that evaluates one of four fixed wide Boolean functions of its own six inputs. Each half has its own six data inputs and its own output.

Configuration is loaded serially. A 73-bit shift register takes one bit per clock while the configuration enable is high, and it is left static afterwards. The configuration holds the truth table, a 2-bit function select, a per-input inversion mask and an output inversion bit. The last bit of the chain is presented on a serial output so that several elements can be daisy-chained. Once the configuration is loaded, both outputs are pure combinational functions of the data inputs.

Chain positions are numbered 0 to 72. Position 0 receives the serial input. The bits that end up at positions 0 to 63 hold truth-table entries 0 to 63. Positions 64 and 65 hold the function select, with the LSB at 64. Positions 66 to 71 hold the inversion enables for macro-gate inputs a to f. Position 72 holds the output inversion. A full load therefore shifts in the bit meant for position 72 first and the bit for position 0 last.

Top module: `mg_ble`

## Requirements
- R1: While rst_ni is low, every configuration bit is cleared. After reset, lut_o is 0 for every LUT input and mg_o equals the AND of the six mg_in_i bits.
- R2: On each rising clock edge with cfg_en_i high, the bit at chain position p moves to position p+1, cfg_din_i enters position 0, and cfg_dout_o always shows position 72.
- R3: On a rising edge with cfg_en_i low, the configuration does not change, whatever the value of cfg_din_i.
- R4: lut_o equals the truth-table entry at index lut_in_i, with lut_in_i[0] (input a) as the index LSB. Entry n is stored at chain position n.
- R5: The function select at positions 65:64 chooses the macro-gate function: 0 is F0, 1 is F1, 2 is F2 and 3 is F3.
- R6: F0 is a·b·c·d·e·f, where a to f are the macro-gate inputs after inversion (a = bit 0, f = bit 5).
- R7: F1 is a'b'c' + bcf' + bc'd' + b'ce.
- R8: F2 is ab'cd'e + bcef + def.
- R9: F3 is ab' + a'cd' + b'c' + e' + f'.
- R10: When the bit at chain position 66+k is set, macro-gate input k (0 = a … 5 = f) is inverted before the function logic. Each bit affects only its own input.
- R11: When the bit at chain position 72 is set, mg_o is the complement of the selected function.
- R12: lut_o and mg_o follow changes on lut_in_i and mg_in_i within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Active-low asynchronous reset, clears configuration |
| cfg_en_i | input | 1 | Shift enable for the configuration chain |
| cfg_din_i | input | 1 | Serial configuration input (enters position 0) |
| cfg_dout_o | output | 1 | Serial configuration output (position 72) |
| lut_in_i | input | 6 | LUT inputs, bit 0 is input a |
| mg_in_i | input | 6 | Macro-gate inputs, bit 0 is a, bit 5 is f |
| lut_o | output | 1 | LUT output |
| mg_o | output | 1 | Macro-gate output |

## Verification
After each configuration load, all 64 LUT input patterns are swept against a truth table that is chosen differently for each load. This tells apart a correct index decode from address bits that are swapped or dropped. All 64 macro-gate input patterns are swept for each of the four functions. The sweeps cover inversion masks with a single bit set, multi-bit masks, and both output polarities, so a wrong product term, a misrouted inversion bit or a misplaced select bit shows up as a miscompare on specific vectors. Extra shifts and idle clocks with a toggling serial input confirm that the chain advances by exactly one position per enabled edge and holds otherwise.

// File: rtl/mg_ble_pkg.sv
package mg_ble_pkg;
  localparam int unsigned LUT_K     = 6;
  localparam int unsigned LUT_BITS  = 1 << LUT_K;
  localparam int unsigned MG_IN     = 6;
  localparam int unsigned FSEL_W    = 2;
  localparam int unsigned FSEL_LSB  = LUT_BITS;
  localparam int unsigned INV_LSB   = FSEL_LSB + FSEL_W;
  localparam int unsigned OINV_POS  = INV_LSB + MG_IN;
  localparam int unsigned CFG_LEN   = OINV_POS + 1;

  typedef enum logic [FSEL_W-1:0] {
    MG_AND6  = 2'd0,
    MG_SOP4  = 2'd1,
    MG_SOP3  = 2'd2,
    MG_SOP5  = 2'd3
  } mg_func_e;
endpackage

// File: rtl/mg_cfg_chain.sv
module mg_cfg_chain #(
  parameter int unsigned LEN = 73
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           din_i,
  output logic [LEN-1:0] cfg_o,
  output logic           dout_o
);
  logic [LEN-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (en_i) sr_q <= {sr_q[LEN-2:0], din_i};
  end

  assign cfg_o  = sr_q;
  assign dout_o = sr_q[LEN-1];

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cfg_o)); // R3
  AST_CFG_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cfg_o[0] == $past(din_i)); // R2
  AST_CFG_SHIFT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> dout_o == $past(cfg_o[LEN-2])); // R2
endmodule

// File: rtl/mg_lut.sv
module mg_lut #(
  parameter int unsigned K = 6
) (
  input  logic [(1<<K)-1:0] tt_i,
  input  logic [K-1:0]      sel_i,
  output logic              y_o
);
  localparam int unsigned N = 1 << K;

  // heap-ordered mux tree: node 1 is root, leaves at N..2N-1
  logic [2*N-1:1] node;

  for (genvar l = 0; l < N; l++) begin : g_leaf
    assign node[N+l] = tt_i[l];
  end

  for (genvar d = 0; d < K; d++) begin : g_lvl
    for (genvar j = 0; j < (1 << d); j++) begin : g_mux
      localparam int unsigned I = (1 << d) + j;
      assign node[I] = sel_i[K-1-d] ? node[2*I+1] : node[2*I];
    end
  end

  assign y_o = node[1];

  always_comb begin
    AST_LUT_INDEX: assert (y_o === tt_i[sel_i]); // R4
  end
endmodule

// File: rtl/mg_macro_gate.sv
module mg_macro_gate
  import mg_ble_pkg::*;
#(
  parameter int unsigned W = MG_IN
) (
  input  logic [W-1:0]      x_i,
  input  logic [W-1:0]      inv_i,
  input  logic [FSEL_W-1:0] fsel_i,
  input  logic              oinv_i,
  output logic              y_o
);
  logic [W-1:0] v;
  logic a, b, c, d, e, f;
  logic fn;

  assign v = x_i ^ inv_i;
  assign {f, e, d, c, b, a} = v[5:0];

  always_comb begin
    unique case (mg_func_e'(fsel_i))
      MG_AND6: fn = &v[5:0];
      MG_SOP4: fn = (~a & ~b & ~c) | (b & c & ~f) | (b & ~c & ~d) | (~b & c & e);
      MG_SOP3: fn = (a & ~b & c & ~d & e) | (b & c & e & f) | (d & e & f);
      MG_SOP5: fn = (a & ~b) | (~a & c & ~d) | (~b & ~c) | ~e | ~f;
      default: fn = 1'b0;
    endcase
  end

  assign y_o = fn ^ oinv_i;

  always_comb begin
    if (fsel_i == 2'd0 && inv_i == '0 && !oinv_i)
      AST_AND6_PLAIN: assert (y_o === (x_i == {W{1'b1}})); // R6
    if (fsel_i == 2'd3 && oinv_i == 1'b0 && v[4] == 1'b0)
      AST_SOP5_E_LOW: assert (y_o === 1'b1); // R9
  end
endmodule

// File: rtl/mg_ble.sv
module mg_ble
  import mg_ble_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_din_i,
  output logic             cfg_dout_o,
  input  logic [LUT_K-1:0] lut_in_i,
  input  logic [MG_IN-1:0] mg_in_i,
  output logic             lut_o,
  output logic             mg_o
);
  logic [CFG_LEN-1:0] cfg;

  mg_cfg_chain #(.LEN(CFG_LEN)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_en_i),
    .din_i  (cfg_din_i),
    .cfg_o  (cfg),
    .dout_o (cfg_dout_o)
  );

  mg_lut #(.K(LUT_K)) u_lut (
    .tt_i  (cfg[LUT_BITS-1:0]),
    .sel_i (lut_in_i),
    .y_o   (lut_o)
  );

  mg_macro_gate #(.W(MG_IN)) u_mg (
    .x_i    (mg_in_i),
    .inv_i  (cfg[INV_LSB +: MG_IN]),
    .fsel_i (cfg[FSEL_LSB +: FSEL_W]),
    .oinv_i (cfg[OINV_POS]),
    .y_o    (mg_o)
  );

  AST_RESET_LUT_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> !lut_o); // R1
endmodule

// File: tb/mg_ble_tb_top.sv
module mg_ble_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLEN = 73;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic cfg_din = 1'b0;
  logic cfg_dout;
  logic [5:0] lut_in = '0;
  logic [5:0] mg_in = '0;
  logic lut_y, mg_y;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mg_ble dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_din_i(cfg_din),
    .cfg_dout_o(cfg_dout), .lut_in_i(lut_in), .mg_in_i(mg_in),
    .lut_o(lut_y), .mg_o(mg_y)
  );

  function automatic logic ref_mg(logic [1:0] sel, logic [5:0] inv, logic oinv, logic [5:0] x);
    logic [5:0] v;
    logic a, b, c, d, e, f, r;
    v = x ^ inv;
    a = v[0]; b = v[1]; c = v[2]; d = v[3]; e = v[4]; f = v[5];
    case (sel)
      2'd0: r = a & b & c & d & e & f;
      2'd1: r = (!a && !b && !c) || (b && c && !f) || (b && !c && !d) || (!b && c && e);
      2'd2: r = (a && !b && c && !d && e) || (b && c && e && f) || (d && e && f);
      default: r = (a && !b) || (!a && c && !d) || (!b && !c) || !e || !f;
    endcase
    return r ^ oinv;
  endfunction

  function automatic logic [CLEN-1:0] mk_cfg(logic [63:0] tt, logic [1:0] sel, logic [5:0] inv, logic oinv);
    return {oinv, inv, sel, tt};
  endfunction

  task automatic check(logic act, logic exp, string req, string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic load(logic [CLEN-1:0] c);
    for (int i = CLEN-1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_din = c[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic sweep(logic [CLEN-1:0] c, string req);
    for (int i = 0; i < 64; i++) begin
      lut_in = i[5:0];
      mg_in = i[5:0];
      #1;
      check(lut_y, c[i], "R4", req);
      check(mg_y, ref_mg(c[65:64], c[71:66], c[72], i[5:0]), req, "mg");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [CLEN-1:0] c;
    logic [63:0] tt;
    logic [5:0] masks [8];
    masks = '{6'h01, 6'h02, 6'h04, 6'h08, 6'h10, 6'h20, 6'h2a, 6'h3f};

    repeat (3) @(negedge clk);
    // R1: reset clears everything
    for (int i = 0; i < 64; i++) begin
      lut_in = i[5:0]; mg_in = i[5:0]; #1;
      check(lut_y, 1'b0, "R1", "lut in reset");
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_dout, 1'b0, "R1", "dout after reset");
    for (int i = 0; i < 64; i++) begin
      lut_in = i[5:0]; mg_in = i[5:0]; #1;
      check(lut_y, 1'b0, "R1", "lut after reset");
      check(mg_y, (i == 63), "R1", "and6 after reset");
    end

    // R5..R9 with R4: each function, plain polarity, distinct truth tables
    for (int s = 0; s < 4; s++) begin
      tt = 64'hc3a5_f00f_1e2d_9b6a;
      tt = (tt << (s*7)) | (tt >> (64 - s*7)) ^ {16{s[3:0]}};
      c = mk_cfg(tt, s[1:0], 6'h00, 1'b0);
      load(c);
      check(cfg_dout, c[72], "R2", "dout after load");
      case (s)
        0: sweep(c, "R6");
        1: sweep(c, "R7");
        2: sweep(c, "R8");
        default: sweep(c, "R9");
      endcase
    end

    // R10/R11: inversion masks and output polarity for every function
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 8; m++) begin
        for (int o = 0; o < 2; o++) begin
          tt = {masks[m], 26'h2b5_a5a5, s[1:0], 30'h1234_5678} ^ {64{o[0]}};
          c = mk_cfg(tt, s[1:0], masks[m], o[0]);
          load(c);
          sweep(c, o[0] ? "R11" : "R10");
        end
      end
    end

    // R2: one extra enabled shift moves every bit up by one
    c = mk_cfg(64'h8000_0000_0000_0001, 2'd1, 6'h15, 1'b0);
    load(c);
    @(negedge clk);
    cfg_en = 1'b1; cfg_din = 1'b0;
    @(negedge clk);
    cfg_en = 1'b0;
    check(cfg_dout, c[71], "R2", "dout after extra shift");
    c = {c[71:0], 1'b0};
    sweep(c, "R2");

    // R3: idle clocks with toggling serial input change nothing
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cfg_din = ~cfg_din;
    end
    check(cfg_dout, c[72], "R3", "dout held");
    sweep(c, "R3");

    // R12: outputs follow inputs between clock edges
    for (int i = 0; i < 64; i++) begin
      @(posedge clk);
      #2;
      lut_in = i[5:0]; mg_in = ~i[5:0];
      #1;
      check(lut_y, c[i], "R12", "lut between edges");
      check(mg_y, ref_mg(c[65:64], c[71:66], c[72], ~i[5:0]), "R12", "mg between edges");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule